// File: doc/BRIEF.md
# I2C Bus Error Monitor

This block watches the two lines of an I2C bus and catches START and STOP conditions that arrive in the middle of a byte. Both lines pass through a chain of synchronizing flops. An edge detector then finds SCL rising edges, STOP conditions (SDA rising while SCL is high) and START conditions (SDA falling while SCL is high). A tracker counts the SCL clocks that have finished within the current byte. A condition that arrives after one to eight data clocks of a byte is out of place. It sets a sticky error flag, moves the monitor into a halt state and emits a one-cycle pulse. The transfer engine next to this block uses that pulse to clear its own transfer-interrupt enable and to abort the byte.

Software sees two bits: the error flag and a bus-error interrupt enable. Both are written together through a single write strobe. The flag can only be cleared, by writing 0. Writing 1 leaves it as it is. The interrupt request follows the flag gated by the enable. All pins are plain control and status pins. No data stream crosses the block's edge, so there is no valid/ready handshake.

Top module: `i2c_bus_err_mon`

## Requirements
- R1: After reset, `err_flag`, `err_ie`, `irq`, `halt` and `xfer_ie_clr` are all 0.
- R2: A START seen while a frame is open, after 1 to 8 completed SCL clocks of the current byte, sets `err_flag`. The SCL rise that carries the START is the clock in progress and is not counted as completed.
- R3: A START or STOP seen after 0 or exactly 9 completed clocks (start of a byte, or after the acknowledge clock) leaves `err_flag` at 0. This includes a repeated START between bytes.
- R4: A STOP seen after 1 to 8 completed clocks of an open frame sets `err_flag`.
- R5: A register write with `wr_err`=0 clears `err_flag`. A write with `wr_err`=1 leaves it unchanged. A new error in the same cycle as a clearing write wins.
- R6: `irq` is 1 exactly when `err_flag` and `err_ie` are both 1. A write sets `err_ie` to `wr_ie`.
- R7: Each detected error drives `xfer_ie_clr` high for one clock, in the same cycle in which `err_flag` is 1.
- R8: `halt` goes high together with `err_flag`, stays high until the flag is cleared, and then returns to 0 (idle).
- R9: SCL clocks outside a frame (after a STOP, before the next START) are not counted, so a STOP there raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| wr_en | input | 1 | Register write strobe |
| wr_err | input | 1 | Write value for the error flag (0 clears) |
| wr_ie | input | 1 | Write value for the bus-error interrupt enable |
| err_flag | output | 1 | Sticky bus-error flag |
| err_ie | output | 1 | Bus-error interrupt enable |
| irq | output | 1 | Interrupt request to the CPU |
| halt | output | 1 | Interface held in halt state |
| xfer_ie_clr | output | 1 | One-cycle pulse clearing the engine's transfer-interrupt enable |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 and `FRAME_BITS` = 9. The deeper synchronizer checks that detection latency does not shift the bit-position accounting. The frame length of 9 places the legal boundaries at 0 and 9 completed clocks, so the bench can aim a START at the fourth bit and at the first bit, and a STOP at the eighth bit, of a real byte. With these values the bench also reaches the legal repeated START right after an acknowledge clock, and SCL clocks on an idle bus.

// File: rtl/i2c_bem_pkg.sv
package i2c_bem_pkg;
  typedef enum logic {MON_IDLE = 1'b0, MON_HALT = 1'b1} mon_state_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } bus_ev_t;
endpackage

// File: rtl/i2c_bem_sync.sv
module i2c_bem_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_bem_cond.sv
module i2c_bem_cond
  import i2c_bem_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_s,
  input  logic    sda_s,
  output bus_ev_t ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    ev.scl_rise = scl_s & ~scl_q;
    ev.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/i2c_bem_track.sv
module i2c_bem_track
  import i2c_bem_pkg::*;
#(
  parameter int FRAME_BITS = 9
) (
  input  logic    clk,
  input  logic    rst_n,
  input  bus_ev_t ev,
  output logic    bad_cond
);
  localparam int CW = $clog2(FRAME_BITS + 2);
  localparam logic [CW-1:0] WRAP_AT = CW'(FRAME_BITS + 1);
  localparam logic [CW-1:0] FIRST_BAD = CW'(2);
  localparam logic [CW-1:0] LAST_BAD  = CW'(FRAME_BITS);

  logic [CW-1:0] rises;
  logic          in_frame;

  // rises counts SCL rises in the frame; the rise in progress is not yet complete
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises    <= '0;
      in_frame <= 1'b0;
    end else if (ev.start || ev.stop) begin
      rises    <= '0;
      in_frame <= ev.start;
    end else if (ev.scl_rise && in_frame) begin
      rises <= (rises == WRAP_AT) ? FIRST_BAD : rises + 1'b1;
    end
  end

  assign bad_cond = in_frame && (ev.start || ev.stop) &&
                    (rises >= FIRST_BAD) && (rises <= LAST_BAD);
endmodule

// File: rtl/i2c_bem_regs.sv
module i2c_bem_regs
  import i2c_bem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bad_cond,
  input  logic wr_en,
  input  logic wr_err,
  input  logic wr_ie,
  output logic err_flag,
  output logic err_ie,
  output logic irq,
  output logic halt,
  output logic xfer_ie_clr
);
  mon_state_t state;
  logic       sw_clear;

  assign sw_clear = wr_en && !wr_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag    <= 1'b0;
      err_ie      <= 1'b0;
      xfer_ie_clr <= 1'b0;
      state       <= MON_IDLE;
    end else begin
      if (bad_cond)      err_flag <= 1'b1;
      else if (sw_clear) err_flag <= 1'b0;
      if (wr_en) err_ie <= wr_ie;
      xfer_ie_clr <= bad_cond;
      case (state)
        MON_IDLE: if (bad_cond) state <= MON_HALT;
        MON_HALT: if (!bad_cond && sw_clear) state <= MON_IDLE;
        default:  state <= MON_IDLE;
      endcase
    end
  end

  assign halt = (state == MON_HALT);
  assign irq  = err_flag & err_ie;
endmodule

// File: rtl/i2c_bus_err_mon.sv
module i2c_bus_err_mon
  import i2c_bem_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  input  logic wr_en,
  input  logic wr_err,
  input  logic wr_ie,
  output logic err_flag,
  output logic err_ie,
  output logic irq,
  output logic halt,
  output logic xfer_ie_clr
);
  logic [1:0] lines_s;
  bus_ev_t    ev;
  logic       bad_cond;

  i2c_bem_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(lines_s)
  );

  i2c_bem_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(lines_s[1]), .sda_s(lines_s[0]), .ev(ev)
  );

  i2c_bem_track #(.FRAME_BITS(FRAME_BITS)) u_track (
    .clk(clk), .rst_n(rst_n), .ev(ev), .bad_cond(bad_cond)
  );

  i2c_bem_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bad_cond(bad_cond),
    .wr_en(wr_en), .wr_err(wr_err), .wr_ie(wr_ie),
    .err_flag(err_flag), .err_ie(err_ie), .irq(irq),
    .halt(halt), .xfer_ie_clr(xfer_ie_clr)
  );
endmodule

// File: rtl/i2c_bem_chk.sv
module i2c_bem_chk (
  input logic clk,
  input logic rst_n,
  input logic bad_cond,
  input logic wr_en,
  input logic wr_err,
  input logic err_flag,
  input logic err_ie,
  input logic irq,
  input logic halt,
  input logic xfer_ie_clr
);
  // R2
  bad_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cond |=> err_flag);
  // R5
  wr_one_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && wr_en && wr_err && !bad_cond) |=> err_flag);
  // R5
  wr_zero_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && !bad_cond) |=> !err_flag);
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (err_flag && err_ie));
  // R7
  clr_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ie_clr |-> err_flag);
  // R7
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ie_clr && !bad_cond) |=> !xfer_ie_clr);
  // R8
  halt_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt == err_flag);
endmodule

bind i2c_bus_err_mon i2c_bem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bad_cond(bad_cond), .wr_en(wr_en), .wr_err(wr_err),
  .err_flag(err_flag), .err_ie(err_ie), .irq(irq), .halt(halt),
  .xfer_ie_clr(xfer_ie_clr)
);

// File: tb/i2c_bus_err_mon_tb.sv
`timescale 1ns/1ps
module i2c_bus_err_mon_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic wr_en = 1'b0, wr_err = 1'b0, wr_ie = 1'b0;
  logic err_flag, err_ie, irq, halt, xfer_ie_clr;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  i2c_bus_err_mon #(.SYNC_STAGES(3), .FRAME_BITS(9)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .wr_en(wr_en), .wr_err(wr_err), .wr_ie(wr_ie),
    .err_flag(err_flag), .err_ie(err_ie), .irq(irq), .halt(halt),
    .xfer_ie_clr(xfer_ie_clr)
  );

  always @(posedge clk) if (rst_n && xfer_ie_clr) pulses++;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic lines(input logic c, input logic d);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_start();
    if (scl == 1'b0) begin
      lines(1'b0, 1'b1);
      lines(1'b1, 1'b1);
    end
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0);
  endtask

  task automatic bus_bit(input logic b);
    lines(1'b0, b);
    lines(1'b1, b);
    lines(1'b0, b);
  endtask

  task automatic bus_stop();
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
  endtask

  task automatic bus_bits(input int n);
    for (int i = 0; i < n; i++) bus_bit(i[0]);
  endtask

  task automatic reg_write(input logic e, input logic ie);
    @(negedge clk);
    wr_en = 1'b1; wr_err = e; wr_ie = ie;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 err_flag", err_flag, 1'b0);
    chk("R1 err_ie", err_ie, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 halt", halt, 1'b0);
    chk("R1 xfer_ie_clr", xfer_ie_clr, 1'b0);
  endtask

  task automatic t_legal_frames();
    bus_start(); bus_bits(9); bus_stop();
    chk("R3 stop after ack", err_flag, 1'b0);
    bus_start(); bus_bits(9); bus_start(); bus_bits(9); bus_bits(9); bus_stop();
    chk("R3 repeated start between bytes", err_flag, 1'b0);
    chk_int("R3 no clear pulse", pulses, 0);
  endtask

  task automatic t_idle_clocks();
    lines(1'b0, 1'b1);
    bus_bits(4);
    bus_stop();
    chk("R9 stop outside frame", err_flag, 1'b0);
  endtask

  task automatic t_start_bit4();
    bus_start(); bus_bits(4); bus_start();
    chk("R2 start at bit 4 sets flag", err_flag, 1'b1);
    chk("R8 halt with flag", halt, 1'b1);
    chk_int("R7 one clear pulse", pulses, 1);
    chk("R6 irq masked", irq, 1'b0);
    reg_write(1'b1, 1'b1);
    chk("R5 write 1 keeps flag", err_flag, 1'b1);
    chk("R6 irq enabled", irq, 1'b1);
    chk("R8 halt held", halt, 1'b1);
    reg_write(1'b0, 1'b1);
    chk("R5 write 0 clears flag", err_flag, 1'b0);
    chk("R6 irq drops", irq, 1'b0);
    chk("R8 back to idle", halt, 1'b0);
    bus_stop();
    chk("R3 stop at byte start", err_flag, 1'b0);
  endtask

  task automatic t_start_bit1();
    bus_start(); bus_bits(1); bus_start();
    chk("R2 start after one bit", err_flag, 1'b1);
    chk("R6 irq raised", irq, 1'b1);
    chk_int("R7 second pulse", pulses, 2);
    reg_write(1'b0, 1'b0);
    chk("R5 cleared again", err_flag, 1'b0);
    bus_stop();
  endtask

  task automatic t_stop_bit8();
    bus_start(); bus_bits(8); bus_stop();
    chk("R4 stop at bit 8", err_flag, 1'b1);
    chk("R6 irq off with ie 0", irq, 1'b0);
    chk_int("R7 third pulse", pulses, 3);
    reg_write(1'b0, 1'b0);
    chk("R8 idle after clear", halt, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (8) @(posedge clk);
        @(negedge clk);
        t_legal_frames();
        t_idle_clocks();
        t_start_bit4();
        t_start_bit1();
        t_stop_bit8();
        done = 1'b1;
      end
      begin
        repeat (100000) @(posedge clk);
        if (!done) begin
          checks++;
          fails++;
          $display("FAIL watchdog: got timeout expected completion");
        end
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule